// File: doc/BRIEF.md
# SDRAM Read Burst Sequencer

This block is the device-side read path of a pipelined single-data-rate SDRAM. It takes READ commands that carry a bank, a starting column and an auto-precharge flag. It walks the burst's column addresses into a synchronous storage array that returns data one clock after an address is presented. It then drives one data word per clock on the output, starting a programmable CAS latency after the command, with an output enable that stands for the tri-state bus.

The burst length is taken from a mode input when the command is sampled. Fixed-length bursts wrap inside their aligned block of columns. Full-page bursts run around the 256-column page until another READ replaces them. A READ is accepted on any clock. A READ that arrives during a burst cuts that burst off, and its first word follows the old burst's last wanted word with no gap. When a fixed-length burst with auto precharge runs to its end, the block pulses a per-bank precharge-done flag.

Top module: `sdram_rd_seq`

## Requirements
- R1: While rst_ni is low, dq_oe_o, dq_o, mem_rd_o and pre_done_o are all zero.
- R2: A READ sampled at clock edge n puts the word from its starting column on dq_o, with dq_oe_o high, right after edge n+2 when cas_lat_i is 0 (latency 2), and right after edge n+3 when cas_lat_i is 1 (latency 3).
- R3: Burst words follow one per clock. The burst_mode_i code sampled with the READ sets the length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4, 5 and 6 give 1 word.
- R4: In a fixed burst of length L from start column s, word k reads column (s & ~(L-1)) | ((s+k) & (L-1)).
- R5: In a full-page burst, word k reads column (s+k) mod 256. The burst continues until another READ takes effect.
- R6: After the last word of a burst that nothing replaces, dq_oe_o is low from the next clock on. dq_o is zero whenever dq_oe_o is low.
- R7: A READ sampled at edge n during a burst replaces the old burst's words from edge n+CL onward. Words before that edge are unchanged, so the output stays continuous.
- R8: A READ is accepted on every clock, including consecutive clocks and any bank. A READ sampled exactly L clocks after a length-L READ makes its data follow with no idle cycle.
- R9: When a fixed-length burst with the auto-precharge flag set runs to completion, pre_done_o[bank] is high for exactly the one clock in which its last word is on dq_o. There is no pulse if the flag is clear or if the burst is truncated before its last word.
- R10: The storage address (mem_rd_o, mem_bank_o, mem_col_o) for each word is presented exactly two clocks before that word appears on dq_o. The word's value is the array data returned for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 1 | CAS latency select: 0 = 2 clocks, 1 = 3 clocks |
| burst_mode_i | input | 3 | Burst length code, sampled with each READ |
| rd_cmd_i | input | 1 | READ command strobe |
| rd_bank_i | input | 2 | Bank of the READ |
| rd_col_i | input | 8 | Starting column of the READ |
| rd_ap_i | input | 1 | Auto-precharge enable for the READ |
| mem_rd_o | output | 1 | Storage read strobe |
| mem_bank_o | output | 2 | Storage bank address |
| mem_col_o | output | 8 | Storage column address |
| mem_data_i | input | 16 | Storage read data, valid one clock after the address |
| dq_o | output | 16 | Data output word |
| dq_oe_o | output | 1 | Data output enable; low means the bus is released |
| pre_done_o | output | 4 | One-clock precharge-done pulse per bank |

## Verification
Several properties are checked on every clock. The output enable must track the address strobe two clocks earlier. A new address stream must start only after a READ one or two clocks before. Precharge-done pulses must be one-hot and must fall only on cycles that carry a data word. The bench's scenarios are the only way to show the actual column sequences: aligned wrapping, page wrapping, where truncation cuts over at each command spacing, the seamless joining of back-to-back bursts, and which bursts earn a precharge pulse. In those scenarios an arithmetic model predicts every output on every cycle.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic {
    CL_TWO   = 1'b0,
    CL_THREE = 1'b1
  } cas_lat_e;

  localparam logic [2:0] BM_PAGE = 3'b111;

  // log2 of the fixed burst length; unused codes behave as length 1
  function automatic logic [1:0] burst_log2(input logic [2:0] mode);
    case (mode)
      3'd1:    return 2'd1;
      3'd2:    return 2'd2;
      3'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_page(input logic [2:0] mode);
    return mode == BM_PAGE;
  endfunction

endpackage

// File: rtl/sdram_rd_cmd_align.sv
module sdram_rd_cmd_align
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cl_sel_i,
  input  logic              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [2:0]        mode_i,
  output logic              ld_o,
  output logic [BANK_W-1:0] ld_bank_o,
  output logic [COL_W-1:0]  ld_col_o,
  output logic              ld_ap_o,
  output logic [2:0]        ld_mode_o
);

  logic              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              ap_q;
  logic [2:0]        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      mode_q <= '0;
    end else begin
      cmd_q  <= cmd_i;
      bank_q <= bank_i;
      col_q  <= col_i;
      ap_q   <= ap_i;
      mode_q <= mode_i;
    end
  end

  // latency 3 loads the burst generator one clock later than latency 2
  always_comb begin
    if (cas_lat_e'(cl_sel_i) == CL_THREE) begin
      ld_o      = cmd_q;
      ld_bank_o = bank_q;
      ld_col_o  = col_q;
      ld_ap_o   = ap_q;
      ld_mode_o = mode_q;
    end else begin
      ld_o      = cmd_i;
      ld_bank_o = bank_i;
      ld_col_o  = col_i;
      ld_ap_o   = ap_i;
      ld_mode_o = mode_i;
    end
  end

endmodule

// File: rtl/sdram_rd_burst_gen.sv
module sdram_rd_burst_gen
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int NB     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] ld_bank_i,
  input  logic [COL_W-1:0]  ld_col_i,
  input  logic              ld_ap_i,
  input  logic [2:0]        ld_mode_i,
  output logic              act_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [NB-1:0]     done_o
);

  localparam int REM_W = 3;

  logic              act_q, page_q, ap_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [REM_W-1:0]  rem_q;
  logic [1:0]        lg_q;

  logic [COL_W-1:0]  mask, col_inc, col_nxt;
  logic              last;

  always_comb begin
    mask    = (COL_W'(1) << lg_q) - COL_W'(1);
    col_inc = col_q + COL_W'(1);
    col_nxt = page_q ? col_inc : ((col_q & ~mask) | (col_inc & mask));
    last    = act_q && !page_q && (rem_q == '0);
    done_o  = (last && ap_q) ? (NB'(1) << bank_q) : '0;
  end

  // a new load always wins: this is what truncates the older burst
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      rem_q  <= '0;
      lg_q   <= '0;
    end else if (ld_i) begin
      act_q  <= 1'b1;
      page_q <= is_page(ld_mode_i);
      ap_q   <= ld_ap_i;
      bank_q <= ld_bank_i;
      col_q  <= ld_col_i;
      lg_q   <= burst_log2(ld_mode_i);
      rem_q  <= ~({REM_W{1'b1}} << burst_log2(ld_mode_i));
    end else if (last) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      col_q <= col_nxt;
      rem_q <= rem_q - REM_W'(1);
    end
  end

  assign act_o  = act_q;
  assign bank_o = bank_q;
  assign col_o  = col_q;

endmodule

// File: rtl/sdram_rd_out_stage.sv
module sdram_rd_out_stage #(
  parameter int DATA_W = 16,
  parameter int NB     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_i,
  input  logic [NB-1:0]     done_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [NB-1:0]     pre_done_o
);

  logic          dat_vld_q;
  logic [NB-1:0] pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_vld_q  <= 1'b0;
      pd_q       <= '0;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
      pre_done_o <= '0;
    end else begin
      dat_vld_q  <= iss_i;
      pd_q       <= done_i;
      dq_o       <= dat_vld_q ? mem_data_i : '0;
      dq_oe_o    <= dat_vld_q;
      pre_done_o <= pd_q;
    end
  end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 8,
  parameter int BANK_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cas_lat_i,
  input  logic [2:0]             burst_mode_i,
  input  logic                   rd_cmd_i,
  input  logic [BANK_W-1:0]      rd_bank_i,
  input  logic [COL_W-1:0]       rd_col_i,
  input  logic                   rd_ap_i,
  output logic                   mem_rd_o,
  output logic [BANK_W-1:0]      mem_bank_o,
  output logic [COL_W-1:0]       mem_col_o,
  input  logic [DATA_W-1:0]      mem_data_i,
  output logic [DATA_W-1:0]      dq_o,
  output logic                   dq_oe_o,
  output logic [(1<<BANK_W)-1:0] pre_done_o
);

  localparam int NB = 1 << BANK_W;

  logic              ld;
  logic [BANK_W-1:0] ld_bank;
  logic [COL_W-1:0]  ld_col;
  logic              ld_ap;
  logic [2:0]        ld_mode;
  logic [NB-1:0]     done;

  sdram_rd_cmd_align #(.BANK_W(BANK_W), .COL_W(COL_W)) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cl_sel_i  (cas_lat_i),
    .cmd_i     (rd_cmd_i),
    .bank_i    (rd_bank_i),
    .col_i     (rd_col_i),
    .ap_i      (rd_ap_i),
    .mode_i    (burst_mode_i),
    .ld_o      (ld),
    .ld_bank_o (ld_bank),
    .ld_col_o  (ld_col),
    .ld_ap_o   (ld_ap),
    .ld_mode_o (ld_mode)
  );

  sdram_rd_burst_gen #(.BANK_W(BANK_W), .COL_W(COL_W), .NB(NB)) u_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld),
    .ld_bank_i (ld_bank),
    .ld_col_i  (ld_col),
    .ld_ap_i   (ld_ap),
    .ld_mode_i (ld_mode),
    .act_o     (mem_rd_o),
    .bank_o    (mem_bank_o),
    .col_o     (mem_col_o),
    .done_o    (done)
  );

  sdram_rd_out_stage #(.DATA_W(DATA_W), .NB(NB)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .iss_i      (mem_rd_o),
    .done_i     (done),
    .mem_data_i (mem_data_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .pre_done_o (pre_done_o)
  );

endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
  parameter int BANK_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   rd_cmd_i,
  input logic                   mem_rd_o,
  input logic                   dq_oe_o,
  input logic [(1<<BANK_W)-1:0] pre_done_o
);

  logic [1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  a_r1_quiet_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 2'd0) |-> (!mem_rd_o && !dq_oe_o && pre_done_o == '0));

  a_r6_oe_tracks_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2) |-> (dq_oe_o == $past(mem_rd_o, 2)));

  a_r2_issue_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2 && $rose(mem_rd_o)) |-> ($past(rd_cmd_i) || $past(rd_cmd_i, 2)));

  a_r9_pd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pre_done_o));

  a_r9_pd_on_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_done_o != '0) |-> dq_oe_o);

endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_cmd_i   (rd_cmd_i),
  .mem_rd_o   (mem_rd_o),
  .dq_oe_o    (dq_oe_o),
  .pre_done_o (pre_done_o)
);

// File: tb/sdram_rd_seq_test.sv
`timescale 1ns/1ps
module sdram_rd_seq_test;

  localparam int NCYC = 8192;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cas_lat_i = 1'b0;
  logic [2:0]  burst_mode_i = '0;
  logic        rd_cmd_i = 1'b0;
  logic [1:0]  rd_bank_i = '0;
  logic [7:0]  rd_col_i = '0;
  logic        rd_ap_i = 1'b0;
  logic        mem_rd_o;
  logic [1:0]  mem_bank_o;
  logic [7:0]  mem_col_o;
  logic [15:0] mem_data_i = '0;
  logic [15:0] dq_o;
  logic        dq_oe_o;
  logic [3:0]  pre_done_o;

  sdram_rd_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .cas_lat_i(cas_lat_i), .burst_mode_i(burst_mode_i),
    .rd_cmd_i(rd_cmd_i), .rd_bank_i(rd_bank_i), .rd_col_i(rd_col_i), .rd_ap_i(rd_ap_i),
    .mem_rd_o(mem_rd_o), .mem_bank_o(mem_bank_o), .mem_col_o(mem_col_o),
    .mem_data_i(mem_data_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .pre_done_o(pre_done_o)
  );

  always #2.5 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    mon_en = 1'b0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  logic        exp_oe [NCYC];
  logic [15:0] exp_dq [NCYC];
  logic [3:0]  exp_pd [NCYC];

  function automatic logic [15:0] word_of(input logic [1:0] b, input logic [7:0] c);
    return {4'hA, 2'b00, b, c};
  endfunction

  // synchronous storage array: data one clock after the address
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_o) mem_data_i <= word_of(mem_bank_o, mem_col_o);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      chk(1'b0, "watchdog", "timeout", cyc, 100000);
      finish_run();
    end
  end

  // per-cycle comparison against the arithmetic model
  always @(negedge clk) begin
    if (mon_en && cyc + 2 < NCYC) begin
      chk(dq_oe_o == exp_oe[cyc] && dq_o == exp_dq[cyc], cur_req, "dq/oe",
          {15'b0, dq_oe_o, dq_o}, {15'b0, exp_oe[cyc], exp_dq[cyc]});
      chk(pre_done_o == exp_pd[cyc], "R9", "pre_done", 32'(pre_done_o), 32'(exp_pd[cyc]));
      chk(mem_rd_o == exp_oe[cyc+2] &&
          (!mem_rd_o || {mem_bank_o, mem_col_o} == exp_dq[cyc+2][9:0]), "R10", "mem addr",
          {21'b0, mem_rd_o, mem_bank_o, mem_col_o}, {21'b0, exp_oe[cyc+2], exp_dq[cyc+2][9:0]});
    end
  end

  // model: READ sampled at edge n; its words overwrite everything from n+CL on
  task automatic schedule(input int n, input bit cl3, input int mode, input int bank,
                          input int col, input bit ap);
    int s, len;
    bit page;
    s    = n + (cl3 ? 3 : 2);
    page = (mode == 7);
    len  = page ? 600 : ((mode >= 0 && mode <= 3) ? (1 << mode) : 1);
    for (int c = s; c < s + 700 && c < NCYC; c++) begin
      exp_oe[c] = 1'b0; exp_dq[c] = '0; exp_pd[c] = '0;
    end
    for (int k = 0; k < len && s + k < NCYC; k++) begin
      int cc;
      cc = page ? ((col + k) % 256) : ((col & ~(len - 1)) | ((col + k) & (len - 1)));
      exp_oe[s+k] = 1'b1;
      exp_dq[s+k] = word_of(2'(bank), 8'(cc));
    end
    if (!page && ap && s + len - 1 < NCYC) exp_pd[s+len-1] = 4'(1 << bank);
  endtask

  task automatic issue(input int mode, input int bank, input int col, input bit ap);
    burst_mode_i = 3'(mode);
    rd_bank_i    = 2'(bank);
    rd_col_i     = 8'(col);
    rd_ap_i      = ap;
    rd_cmd_i     = 1'b1;
    schedule(cyc + 1, cas_lat_i, mode, bank, col, ap);
    @(negedge clk);
    rd_cmd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int starts [6] = '{0, 3, 6, 7, 249, 255};
  int modes  [6] = '{0, 1, 2, 3, 4, 5};

  initial begin
    for (int c = 0; c < NCYC; c++) begin
      exp_oe[c] = 1'b0; exp_dq[c] = '0; exp_pd[c] = '0;
    end
    // R1: reset state
    idle(3);
    chk(dq_oe_o == 1'b0 && dq_o == '0 && pre_done_o == '0 && mem_rd_o == 1'b0, "R1",
        "reset outputs", {dq_oe_o, dq_o, pre_done_o, mem_rd_o}, '0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(2);

    // R2: first word timing at both latencies
    cur_req = "R2";
    for (int cl = 0; cl < 2; cl++) begin
      cas_lat_i = cl[0];
      issue(0, cl + 1, 8'h33, 1'b1);
      idle(8);
    end

    // R3/R4: sweep lengths, start columns, banks and precharge flag
    for (int cl = 0; cl < 2; cl++) begin
      cas_lat_i = cl[0];
      for (int mi = 0; mi < 6; mi++) begin
        for (int si = 0; si < 6; si++) begin
          cur_req = (modes[mi] == 0 || modes[mi] > 3) ? "R3" : "R4";
          issue(modes[mi], (mi + si) % 4, starts[si], si[0]);
          idle(14);
        end
      end
    end

    // R5: full page wrapping past column 255, then terminated by a new READ
    cur_req = "R5";
    cas_lat_i = 1'b0;
    issue(7, 2, 8'hF0, 1'b1);
    idle(300);
    issue(0, 1, 8'h05, 1'b0);
    idle(10);
    cas_lat_i = 1'b1;
    issue(7, 3, 8'h10, 1'b0);
    idle(40);
    issue(1, 0, 8'h80, 1'b1);
    idle(12);

    // R7: truncation at every spacing, both latencies
    cur_req = "R7";
    for (int cl = 0; cl < 2; cl++) begin
      cas_lat_i = cl[0];
      for (int d = 1; d <= 9; d++) begin
        issue(3, 1, 8'h22, 1'b1);
        idle(d - 1);
        issue(2, 2, 8'h45, 1'b1);
        idle(14);
      end
    end

    // R8: READs on consecutive clocks and a seamless fixed-length join
    cur_req = "R8";
    for (int cl = 0; cl < 2; cl++) begin
      cas_lat_i = cl[0];
      for (int i = 0; i < 6; i++) issue(3, i % 4, 8'h10 * i + 3, 1'b1);
      idle(14);
      issue(2, 0, 8'h41, 1'b1);
      idle(3);
      issue(2, 3, 8'h7E, 1'b1);
      idle(14);
    end

    // R6: bus released after an unfollowed burst, idle stays quiet
    cur_req = "R6";
    cas_lat_i = 1'b0;
    issue(1, 1, 8'hAB, 1'b0);
    idle(20);

    mon_en = 1'b0;
    finish_run();
  end

endmodule